// File: doc/BRIEF.md
# Quad DAC Serial Register Bank

This block is the digital front end of a four-channel converter. A host shifts frames over a three-wire serial link (serial clock, data in, active-low chip select). Each frame holds a two-bit channel address followed by a sixteen-bit code. When chip select returns high, the code is written into the input register of the addressed channel. A separate active-low load input moves the input registers into the converter (DAC) registers. Holding that input low makes the DAC registers follow the input registers, so the double buffering is bypassed.

The serial input is also passed to a serial output after a fixed delay of 19 serial clock edges, so several banks can share one data line in a chain. A scale-reset input returns every register to zero-scale or to midscale; a select input picks which. All serial and control pins are brought into the `clk` domain through a two-flop synchronizer and their edges are detected there. For this reason `clk` must run several times faster than the serial clock. The four DAC register values leave the block as one parallel bus.

Top module: `qdac_bank`

## Requirements
- R1: While `rst_n` is low at a rising `clk` edge, every input register and every DAC register is cleared to 0x0000 and `sdo` is driven to 0.
- R2: A data bit is taken from `sdi` at each rising edge of `sclk` while `cs_n` is low. Rising `sclk` edges while `cs_n` is high change neither the frame shift register nor `sdo`.
- R3: A frame is sent MSB first: the address bit A1, then A0, then code bits D15 down to D0. On each rising edge of `cs_n`, the input register of channel {A1,A0} (0 to 3) takes the code, and the other three are left unchanged. The shift register keeps its contents between frames.
- R4: When more than 18 bits are clocked in one frame, only the last 18 bits clocked in decide the address and the code.
- R5: While `ldac_n` is high, writes to the input registers leave the DAC registers unchanged.
- R6: A low pulse on `ldac_n` copies all four input registers into the DAC registers. After `ldac_n` returns high, the DAC registers hold those values.
- R7: While `ldac_n` is held low, each DAC register follows its input register, so a frame reaches `dac_code` with no separate load.
- R8: While `scale_rst_n` is low, all input and DAC registers are loaded with 0x8000 if `scale_mid` is 1, and with 0x0000 if it is 0. This takes priority over a frame write and over a load.
- R9: After the n-th accepted `sclk` edge since reset, `sdo` shows the bit accepted at edge n-19. It shows 0 while n is 19 or less, and it changes only on accepted edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all serial and control pins |
| rst_n | input | 1 | Synchronous active-low power-on clear |
| sclk | input | 1 | Serial clock, data taken on its rising edge |
| sdi | input | 1 | Serial data in |
| cs_n | input | 1 | Active-low frame select; its rising edge commits the frame |
| ldac_n | input | 1 | Active-low load: copies input registers to DAC registers |
| scale_rst_n | input | 1 | Active-low scale reset of all registers |
| scale_mid | input | 1 | Scale reset value select: 1 midscale, 0 zero-scale |
| sdo | output | 1 | Delayed serial data out for chaining |
| dac_code | output | 64 | DAC register values, channel k in bits [16k+15:16k] |

## Verification
Errors inside the block show up in two places at the ports. A fault in the shift register or the address decode puts a wrong code on the wrong channel of `dac_code`, but only once a load makes it visible, which is a few `clk` cycles after the `ldac_n` edge. A fault in the double-buffer path shows as a DAC output that moves while loads are off, or that stays put while `ldac_n` is low. A wrong delay length on the chain line shows at `sdo` at the very next accepted `sclk` edge, compared against the full bit history the bench keeps since reset.

// File: rtl/qdac_pkg.sv
// Shared sizes for the quad DAC register bank.
// Assumes the channel count is a power of two so the address field is exact.
package qdac_pkg;
    localparam int CH_N      = 4;
    localparam int CODE_W    = 16;
    localparam int CHAIN_DLY = 19;
    localparam int ADDR_W    = $clog2(CH_N);
    localparam int FRAME_W   = ADDR_W + CODE_W;
endpackage

// File: rtl/qdac_sync.sv
// Two-flop synchronizer for a bundle of slow pins into the clk domain.
// Assumes each pin stays stable for several clk cycles around its edges.
module qdac_sync #(
    parameter int         W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;

    // Two register stages; reset puts every pin at its idle level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= RST_VAL;
            q      <= RST_VAL;
        end else begin
            meta_q <= d;
            q      <= meta_q;
        end
    end
endmodule

// File: rtl/qdac_serial_rx.sv
// Frame receiver: finds rising serial clock edges inside a frame, shifts the
// data bit into the frame register, and flags the rising edge of chip select.
// Assumes synchronized inputs. The register keeps only the last FRAME_W bits.
module qdac_serial_rx #(
    parameter int FRAME_W = 18
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk_s,
    input  logic               sdi_s,
    input  logic               cs_n_s,
    output logic               shift_en,
    output logic [FRAME_W-1:0] frame_q,
    output logic               frame_done
);
    logic sclk_d;
    logic cs_d;

    // Edge detection against the previous synchronized levels.
    assign shift_en   = sclk_s && !sclk_d && !cs_n_s;
    assign frame_done = cs_n_s && !cs_d;

    // Remember the last levels of serial clock and chip select.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            cs_d   <= cs_n_s;
        end
    end

    // Shift MSB first; older bits fall off the top.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            frame_q <= '0;
        end else if (shift_en) begin
            frame_q <= {frame_q[FRAME_W-2:0], sdi_s};
        end
    end

    AST_SHIFT_IN: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> frame_q[0] == $past(sdi_s)); // R2
    AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(frame_q)); // R2
endmodule

// File: rtl/qdac_chain.sv
// Daisy-chain delay line: each accepted serial bit reappears at sdo
// DLY accepted edges later. Assumes DLY of at least 2.
module qdac_chain #(
    parameter int DLY = 19
) (
    input  logic clk,
    input  logic rst_n,
    input  logic shift_en,
    input  logic sdi_s,
    output logic sdo
);
    logic [DLY-1:0] line_q;

    // Advance the line and the output stage together, once per accepted edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            sdo    <= 1'b0;
        end else if (shift_en) begin
            line_q <= {line_q[DLY-2:0], sdi_s};
            sdo    <= line_q[DLY-1];
        end
    end

    AST_SDO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(sdo)); // R9
endmodule

// File: rtl/qdac_chan.sv
// One channel: input register plus DAC register.
// Priority order: power-on clear, then scale reset, then write and load.
// Assumes wr_en is a one-cycle pulse and load is a level.
module qdac_chan #(
    parameter int CODE_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CODE_W-1:0] wr_data,
    input  logic              load,
    input  logic              clr,
    input  logic [CODE_W-1:0] clr_val,
    output logic [CODE_W-1:0] dac_q
);
    logic [CODE_W-1:0] in_q;

    // Input register: takes a committed frame code.
    always_ff @(posedge clk) begin
        if (!rst_n)
            in_q <= '0;
        else if (clr)
            in_q <= clr_val;
        else if (wr_en)
            in_q <= wr_data;
    end

    // DAC register: copies the input register while load is active.
    always_ff @(posedge clk) begin
        if (!rst_n)
            dac_q <= '0;
        else if (clr)
            dac_q <= clr_val;
        else if (load)
            dac_q <= in_q;
    end

    AST_SCALE_VAL: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (in_q == $past(clr_val)) && (dac_q == $past(clr_val))); // R8
    AST_WR_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && wr_en) |=> in_q == $past(wr_data)); // R3
    AST_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !wr_en) |=> $stable(in_q)); // R3
    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && !load) |=> $stable(dac_q)); // R5
    AST_DAC_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && load) |=> dac_q == $past(in_q)); // R6
endmodule

// File: rtl/qdac_bank.sv
// Quad DAC serial register bank top. Brings the serial and control pins into
// the clk domain, receives frames, decodes the address and drives the channel
// slices and the chain output. Assumes clk runs at least 8x faster than sclk.
module qdac_bank
    import qdac_pkg::*;
#(
    parameter int N_CH    = CH_N,
    parameter int C_W     = CODE_W,
    parameter int DLY     = CHAIN_DLY
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sclk,
    input  logic                sdi,
    input  logic                cs_n,
    input  logic                ldac_n,
    input  logic                scale_rst_n,
    input  logic                scale_mid,
    output logic                sdo,
    output logic [N_CH*C_W-1:0] dac_code
);
    localparam int A_W = $clog2(N_CH);
    localparam int F_W = A_W + C_W;
    localparam logic [C_W-1:0] MID_CODE = {1'b1, {(C_W-1){1'b0}}};
    localparam logic [5:0] PIN_IDLE = 6'b001110;

    logic [5:0]     pins_s;
    logic           sclk_s, sdi_s, cs_n_s, ldac_n_s, scale_rst_n_s, scale_mid_s;
    logic           shift_en;
    logic           frame_done;
    logic [F_W-1:0] frame_q;
    logic [A_W-1:0] frame_addr;
    logic [C_W-1:0] frame_code;
    logic [C_W-1:0] clr_val;
    logic [N_CH-1:0] wr_sel;

    qdac_sync #(.W(6), .RST_VAL(PIN_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({sclk, sdi, cs_n, ldac_n, scale_rst_n, scale_mid}),
        .q     (pins_s)
    );

    // Unpack the synchronized pin bundle.
    assign {sclk_s, sdi_s, cs_n_s, ldac_n_s, scale_rst_n_s, scale_mid_s} = pins_s;

    qdac_serial_rx #(.FRAME_W(F_W)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .sclk_s     (sclk_s),
        .sdi_s      (sdi_s),
        .cs_n_s     (cs_n_s),
        .shift_en   (shift_en),
        .frame_q    (frame_q),
        .frame_done (frame_done)
    );

    qdac_chain #(.DLY(DLY)) u_chain (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .sdi_s    (sdi_s),
        .sdo      (sdo)
    );

    // Split the frame: address on top, code below.
    assign frame_addr = frame_q[F_W-1 -: A_W];
    assign frame_code = frame_q[C_W-1:0];
    assign clr_val    = scale_mid_s ? MID_CODE : '0;

    for (genvar g = 0; g < N_CH; g++) begin : g_chan
        // Address decode for this channel.
        assign wr_sel[g] = frame_done && (frame_addr == A_W'(g));

        qdac_chan #(.CODE_W(C_W)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[g]),
            .wr_data (frame_code),
            .load    (!ldac_n_s),
            .clr     (!scale_rst_n_s),
            .clr_val (clr_val),
            .dac_q   (dac_code[g*C_W +: C_W])
        );
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_sel)); // R3
endmodule

// File: tb/qdac_bank_tb.sv
`timescale 1ns/1ps
module qdac_bank_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic        ldac_n = 1'b1, scale_rst_n = 1'b1, scale_mid = 1'b0;
    logic        sdo;
    logic [63:0] dac_code;

    qdac_bank u_dut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdi(sdi), .cs_n(cs_n),
        .ldac_n(ldac_n), .scale_rst_n(scale_rst_n), .scale_mid(scale_mid),
        .sdo(sdo), .dac_code(dac_code)
    );

    always #2 clk = ~clk;

    typedef struct {
        string       req;
        bit          is_sdo;
        int          ch;
        logic [15:0] exp;
    } item_t;

    item_t       sb_q[$];
    bit          hist[$];
    logic [17:0] m_sreg;
    logic [15:0] m_in [4];
    logic [15:0] m_dac[4];
    int          n_chk = 0, n_fail = 0;
    bit          done = 0;

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bit(bit b);
        sdi = b; tick(3);
        sclk = 1'b1; tick(3);
        sclk = 1'b0; tick(1);
        if (!cs_n) begin
            hist.push_back(b);
            m_sreg = {m_sreg[16:0], b};
        end
    endtask

    task automatic send_bits(logic [31:0] v, int n);
        for (int i = n - 1; i >= 0; i--) send_bit(v[i]);
    endtask

    task automatic commit_model();
        m_in[m_sreg[17:16]] = m_sreg[15:0];
        if (!ldac_n) for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    endtask

    task automatic frame(logic [31:0] v, int n);
        cs_n = 1'b0; tick(4);
        send_bits(v, n);
        tick(4); cs_n = 1'b1; tick(8);
        commit_model();
    endtask

    task automatic pulse_ldac();
        ldac_n = 1'b0; tick(6); ldac_n = 1'b1; tick(6);
        for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
    endtask

    task automatic expect_dac(string req);
        for (int c = 0; c < 4; c++) sb_q.push_back('{req, 1'b0, c, m_dac[c]});
        tick(2);
    endtask

    task automatic expect_sdo(string req);
        item_t it;
        it.req = req; it.is_sdo = 1'b1; it.ch = 0;
        it.exp = (hist.size() >= 20) ? 16'(hist[hist.size() - 20]) : 16'h0;
        sb_q.push_back(it);
        tick(2);
    endtask

    // Monitor: pops expected items and compares them against the ports.
    initial begin
        forever begin
            @(negedge clk);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [15:0] act;
                it = sb_q.pop_front();
                act = it.is_sdo ? 16'(sdo) : dac_code[it.ch*16 +: 16];
                n_chk++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s %s ch%0d actual=%h expected=%h", it.req,
                             it.is_sdo ? "sdo" : "dac", it.ch, act, it.exp);
                end
            end
        end
    end

    // Watchdog: an overlong run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    // Driver: stimulus and model updates.
    initial begin
        m_sreg = '0;
        for (int c = 0; c < 4; c++) begin m_in[c] = '0; m_dac[c] = '0; end
        tick(6); rst_n = 1'b1; tick(4);
        expect_dac("R1");
        expect_sdo("R1");

        // R3 decode, R5 no transfer while loads are off
        frame({14'h0, 2'd0, 16'h1234}, 18);
        frame({14'h0, 2'd1, 16'hFACE}, 18);
        frame({14'h0, 2'd2, 16'h0F0F}, 18);
        frame({14'h0, 2'd3, 16'h8001}, 18);
        expect_dac("R5");
        expect_sdo("R9");
        pulse_ldac();
        expect_dac("R6");
        expect_dac("R3");

        // R5 again: a single channel rewrite stays hidden
        frame({14'h0, 2'd2, 16'hBEEF}, 18);
        expect_dac("R5");

        // R7 transparent mode while the load input is held low
        ldac_n = 1'b0; tick(6);
        for (int c = 0; c < 4; c++) m_dac[c] = m_in[c];
        expect_dac("R7");
        frame({14'h0, 2'd1, 16'h3C5A}, 18);
        expect_dac("R7");
        ldac_n = 1'b1; tick(6);

        // R4 overlong frame: 8 junk bits lead
        frame({6'h0, 8'hFF, 2'd3, 16'hA5C3}, 26);
        expect_sdo("R9");
        pulse_ldac();
        expect_dac("R4");
        frame({2'd0, 2'd0, 12'hABC, 2'd0, 16'h7E81}, 32);
        pulse_ldac();
        expect_dac("R4");

        // R2 edges outside a frame are ignored, then an empty frame recommits
        send_bits(32'h0000_00B7, 8);
        expect_sdo("R2");
        cs_n = 1'b0; tick(6); cs_n = 1'b1; tick(8);
        commit_model();
        frame({14'h0, 2'd2, 16'h0000}, 18);
        cs_n = 1'b0; tick(6); cs_n = 1'b1; tick(8);
        commit_model();
        pulse_ldac();
        expect_dac("R2");
        expect_sdo("R9");

        // R8 midscale reset
        scale_mid = 1'b1; scale_rst_n = 1'b0; tick(6); scale_rst_n = 1'b1; tick(6);
        for (int c = 0; c < 4; c++) begin m_in[c] = 16'h8000; m_dac[c] = 16'h8000; end
        expect_dac("R8");
        pulse_ldac();
        expect_dac("R8");

        // R8 priority: zero-scale reset spans a frame commit and a load
        scale_mid = 1'b0;
        cs_n = 1'b0; tick(4);
        send_bits({14'h0, 2'd1, 16'h4321}, 18);
        tick(2); scale_rst_n = 1'b0; ldac_n = 1'b0; tick(2);
        cs_n = 1'b1; tick(8);
        scale_rst_n = 1'b1; ldac_n = 1'b1; tick(6);
        for (int c = 0; c < 4; c++) begin m_in[c] = 16'h0; m_dac[c] = 16'h0; end
        expect_dac("R8");
        pulse_ldac();
        expect_dac("R8");
        expect_sdo("R9");

        tick(10);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule